// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block decides how a general-purpose up-counter is advanced: freely on the internal clock, held while a quadrature decoder elsewhere owns it, restarted by a trigger edge, gated by a trigger level, armed by a single trigger edge, or stepped by trigger edges used as a slow clock. One of eight trigger lines is picked by a select code. A rising edge on that line is found by comparing it with its value registered one cycle earlier. All inputs are assumed synchronous to `clk`.

A sync option makes the counter act on a trigger one cycle late. It also forwards the raw trigger edge on `trgo`, so a master and the slaves it feeds through that pulse act on the same clock edge. The counter-enable bit is written by software through a strobe. In the start-only mode, hardware sets the bit on the first trigger edge.

The control core is a state machine with seven states. IDLE counts when enabled. ENC holds the counter and exposes the decoder sub-mode. RELOAD counts when enabled and restarts on a trigger edge. GATE counts while enabled and the trigger is high. ARMED waits for a trigger edge. RUN counts while enabled. EXTCLK counts trigger edges. On every clock edge the next state is decoded from the mode code. The start-only mode goes to RUN when the enable bit will be 1 after that edge and to ARMED otherwise. A mode change therefore takes effect one cycle after it is applied.

Top module: `tsm_top`

## Requirements
- R1: Mode codes are 0 idle, 1 to 3 decoder-owned, 4 reload, 5 gated, 6 start-only and 7 edge-clock, and a new code takes effect one cycle later. In codes 1 to 3 the counter holds, `enc_mode` shows the code, and `enc_mode` is 0 in every other mode.
- R2: In idle mode the counter advances by one on each clock edge while `cen` is 1, and holds while `cen` is 0.
- R3: When an advance finds the counter at its all-ones value, the counter wraps to 0 and `upd_evt` is 1 in the cycle before that edge.
- R4: In reload mode a trigger rising edge drives `cnt_rst` and `upd_evt` to 1 and clears the counter at that clock edge. A trigger held high causes no further reload. Otherwise the counter advances while `cen` is 1.
- R5: In gated mode the counter advances only while `cen` is 1 and the trigger is high. When the trigger goes low it holds its value without clearing.
- R6: In start-only mode with `cen` at 0, a trigger rising edge sets `cen` at that edge, and counting starts on the next edge. Later trigger edges or levels have no effect on the count.
- R7: In edge-clock mode each trigger rising edge advances the counter by exactly one, and a trigger held high advances it only once.
- R8: Trigger select code k picks line `trig_in[k]`, except that code 3 is reserved and selects no trigger. Lines that are not selected have no effect.
- R9: With `sync_en` at 1, a trigger edge acts one cycle later than with `sync_en` at 0. `trgo` is 1 in the cycle the selected trigger rises and is always 0 while `sync_en` is 0.
- R10: A `cen_wr` strobe loads `cen_wd` into `cen` and takes priority over the hardware set. A clear in start-only mode stops counting after the edge that loads it.
- R11: After reset the counter is 0, `cen` is 0, the state is IDLE, and `upd_evt`, `cnt_rst`, `trgo` and `enc_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 3 | Mode code (R1) |
| trig_sel | input | SEL_W | Trigger line select, code 3 reserved |
| trig_in | input | N_TRIG | Candidate trigger lines |
| sync_en | input | 1 | One-cycle trigger delay and trigger-output enable |
| cen_wr | input | 1 | Write strobe for the counter-enable bit |
| cen_wd | input | 1 | Value written to the counter-enable bit |
| cnt | output | CNT_W | Counter value |
| cnt_en | output | 1 | Counter advances at the coming edge |
| cnt_rst | output | 1 | Counter reloads at the coming edge |
| upd_evt | output | 1 | Update event (reload or wrap) |
| cen | output | 1 | Counter-enable bit |
| trgo | output | 1 | Forwarded trigger edge pulse |
| enc_mode | output | 2 | Decoder sub-mode, 0 when not decoder-owned |

## Verification
On every cycle, the assertions check the following. The counter only steps by one or goes to 0. An advance at all-ones lands on 0. The decoder, gated and edge-clock states never advance without their condition. An edge while ARMED leaves `cen` set. A delayed edge appears one cycle after the raw one. Only the bench scenarios can show the rest: counts that come out exact over many cycles, that unselected and reserved lines are ignored, that held trigger levels do nothing in the edge modes, and that sync shifts the count by exactly one cycle.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    typedef enum logic [2:0] {
        MD_IDLE   = 3'd0,
        MD_ENC1   = 3'd1,
        MD_ENC2   = 3'd2,
        MD_ENC3   = 3'd3,
        MD_RELOAD = 3'd4,
        MD_GATE   = 3'd5,
        MD_START  = 3'd6,
        MD_EXTCLK = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENC,
        ST_RELOAD,
        ST_GATE,
        ST_ARMED,
        ST_RUN,
        ST_EXTCLK
    } state_e;

endpackage

// File: rtl/tsm_trig_path.sv
module tsm_trig_path #(
    parameter int N_TRIG  = 8,
    parameter int RSV_SEL = 3,
    localparam int SEL_W  = $clog2(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic              sync_en,
    output logic              eff_rise,
    output logic              eff_lvl,
    output logic              trgo
);

    logic line;
    logic line_prev;
    logic rise_raw;
    logic rise_q;
    logic lvl_q;

    always_comb begin
        if (trig_sel == SEL_W'(RSV_SEL)) line = 1'b0;
        else                             line = trig_in[trig_sel];
    end

    assign rise_raw = line & ~line_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_prev <= 1'b0;
            rise_q    <= 1'b0;
            lvl_q     <= 1'b0;
        end else begin
            line_prev <= line;
            rise_q    <= rise_raw;
            lvl_q     <= line;
        end
    end

    assign eff_rise = sync_en ? rise_q : rise_raw;
    assign eff_lvl  = sync_en ? lvl_q  : line;
    assign trgo     = sync_en & rise_raw;

    // R9
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en && rise_raw) |=> (!sync_en || eff_rise));

endmodule

// File: rtl/tsm_mode_fsm.sv
module tsm_mode_fsm
    import tsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       eff_rise,
    input  logic       eff_lvl,
    input  logic       cen_wr,
    input  logic       cen_wd,
    input  logic       at_max,
    output logic       inc,
    output logic       reload,
    output logic       upd,
    output logic       cen,
    output logic [1:0] enc_mode
);

    state_e     state, state_nxt;
    logic       cen_nxt;
    logic [1:0] enc_q;

    always_comb begin
        if (cen_wr)                          cen_nxt = cen_wd;
        else if (state == ST_ARMED && eff_rise) cen_nxt = 1'b1;
        else                                 cen_nxt = cen;
    end

    always_comb begin
        unique case (mode_e'(mode_sel))
            MD_IDLE:                   state_nxt = ST_IDLE;
            MD_ENC1, MD_ENC2, MD_ENC3: state_nxt = ST_ENC;
            MD_RELOAD:                 state_nxt = ST_RELOAD;
            MD_GATE:                   state_nxt = ST_GATE;
            MD_START:                  state_nxt = cen_nxt ? ST_RUN : ST_ARMED;
            MD_EXTCLK:                 state_nxt = ST_EXTCLK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            enc_q <= 2'd0;
        end else begin
            state <= state_nxt;
            enc_q <= mode_sel[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cen <= 1'b0;
        else        cen <= cen_nxt;
    end

    always_comb begin
        inc      = 1'b0;
        reload   = 1'b0;
        enc_mode = 2'd0;
        unique case (state)
            ST_IDLE:   inc = cen;
            ST_ENC:    enc_mode = enc_q;
            ST_RELOAD: begin
                reload = eff_rise;
                inc    = cen & ~eff_rise;
            end
            ST_GATE:   inc = cen & eff_lvl;
            ST_ARMED:  inc = 1'b0;
            ST_RUN:    inc = cen;
            ST_EXTCLK: inc = eff_rise;
            default:   inc = 1'b0;
        endcase
        upd = reload | (inc & at_max);
    end

    // R1
    enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENC) |-> (!inc && !reload));

    // R5
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATE && !eff_lvl) |-> !inc);

    // R6
    arm_sets_cen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && eff_rise && !cen_wr) |=> cen);

    // R7
    extclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXTCLK && !eff_rise) |-> !inc);

endmodule

// File: rtl/tsm_counter.sv
module tsm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             reload,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assign at_max = (cnt == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (reload) cnt <= '0;
        else if (inc)    cnt <= cnt + 1'b1;
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !reload && at_max) |=> (cnt == '0));

endmodule

// File: rtl/tsm_top.sv
module tsm_top #(
    parameter int N_TRIG  = 8,
    parameter int CNT_W   = 16,
    parameter int RSV_SEL = 3,
    localparam int SEL_W  = $clog2(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              sync_en,
    input  logic              cen_wr,
    input  logic              cen_wd,
    output logic [CNT_W-1:0]  cnt,
    output logic              cnt_en,
    output logic              cnt_rst,
    output logic              upd_evt,
    output logic              cen,
    output logic              trgo,
    output logic [1:0]        enc_mode
);

    logic eff_rise;
    logic eff_lvl;
    logic at_max;

    tsm_trig_path #(.N_TRIG(N_TRIG), .RSV_SEL(RSV_SEL)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .trig_sel (trig_sel),
        .sync_en  (sync_en),
        .eff_rise (eff_rise),
        .eff_lvl  (eff_lvl),
        .trgo     (trgo)
    );

    tsm_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .eff_rise (eff_rise),
        .eff_lvl  (eff_lvl),
        .cen_wr   (cen_wr),
        .cen_wd   (cen_wd),
        .at_max   (at_max),
        .inc      (cnt_en),
        .reload   (cnt_rst),
        .upd      (upd_evt),
        .cen      (cen),
        .enc_mode (enc_mode)
    );

    tsm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (cnt_en),
        .reload (cnt_rst),
        .cnt    (cnt),
        .at_max (at_max)
    );

endmodule

// File: tb/tsm_top_tb.sv
module tsm_top_tb;

    localparam int N_TRIG = 8;
    localparam int CNT_W  = 8;
    localparam int SEL_W  = $clog2(N_TRIG);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        mode_sel = '0;
    logic [SEL_W-1:0]  trig_sel = '0;
    logic [N_TRIG-1:0] trig_in = '0;
    logic              sync_en = 1'b0;
    logic              cen_wr = 1'b0;
    logic              cen_wd = 1'b0;
    logic [CNT_W-1:0]  cnt;
    logic              cnt_en, cnt_rst, upd_evt, cen, trgo;
    logic [1:0]        enc_mode;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tsm_top #(.N_TRIG(N_TRIG), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .trig_sel(trig_sel),
        .trig_in(trig_in), .sync_en(sync_en), .cen_wr(cen_wr), .cen_wd(cen_wd),
        .cnt(cnt), .cnt_en(cnt_en), .cnt_rst(cnt_rst), .upd_evt(upd_evt),
        .cen(cen), .trgo(trgo), .enc_mode(enc_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int md, input int sel, input bit sy);
        rst_n = 1'b0;
        trig_in = '0;
        cen_wr = 1'b0;
        mode_sel = 3'(md);
        trig_sel = SEL_W'(sel);
        sync_en = sy;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic wr_cen(input bit v);
        cen_wr = 1'b1;
        cen_wd = v;
        tick(1);
        cen_wr = 1'b0;
    endtask

    task automatic pulse(input logic [N_TRIG-1:0] m);
        trig_in = m;
        tick(1);
        trig_in = '0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        tick(2);
        #1;
        chk(cnt == 0 && cen == 0, "R11 cnt/cen", int'(cnt) + int'(cen), 0);
        chk(!upd_evt && !cnt_rst && !trgo && enc_mode == 0, "R11 flags",
            int'(upd_evt) + int'(cnt_rst) + int'(trgo) + int'(enc_mode), 0);

        // R2 idle mode holds with cen 0, counts with cen 1
        do_reset(0, 0, 0);
        tick(5);
        chk(cnt == 0, "R2 hold cen0", int'(cnt), 0);
        wr_cen(1'b1);
        chk(cen == 1, "R10 write cen", int'(cen), 1);
        for (int k = 1; k <= 3; k++) begin
            tick(k * 10);
            chk(int'(cnt) == k * (k + 1) * 5, "R2 idle count", int'(cnt), k * (k + 1) * 5);
        end
        // R3 wrap (cnt at 60, step to 255)
        tick(195);
        #1;
        chk(cnt == 8'hFF, "R3 reach max", int'(cnt), 255);
        chk(upd_evt == 1, "R3 upd at wrap", int'(upd_evt), 1);
        tick(1);
        #1;
        chk(cnt == 0 && upd_evt == 0, "R3 wrapped", int'(cnt), 0);

        // R4 reload mode
        do_reset(4, 5, 0);
        wr_cen(1'b1);
        tick(20);
        chk(cnt == 20, "R4 counting", int'(cnt), 20);
        trig_in = 8'h20;
        #1;
        chk(upd_evt && cnt_rst, "R4 reload flags", int'(upd_evt) + int'(cnt_rst), 2);
        tick(1);
        chk(cnt == 0, "R4 cleared", int'(cnt), 0);
        tick(3);
        chk(cnt == 3, "R4 level no reload", int'(cnt), 3);
        trig_in = '0;

        // R5 gated mode
        do_reset(5, 6, 0);
        wr_cen(1'b1);
        tick(4);
        chk(cnt == 0, "R5 low holds", int'(cnt), 0);
        trig_in = 8'h40;
        tick(7);
        trig_in = '0;
        chk(cnt == 7, "R5 high counts", int'(cnt), 7);
        tick(5);
        chk(cnt == 7, "R5 hold not cleared", int'(cnt), 7);
        trig_in = 8'h40;
        tick(3);
        trig_in = '0;
        chk(cnt == 10, "R5 resume", int'(cnt), 10);

        // R6 start-only mode, R10 clear
        do_reset(6, 4, 0);
        tick(3);
        chk(cnt == 0 && cen == 0, "R6 armed idle", int'(cnt), 0);
        pulse(8'h10);
        chk(cen == 1 && cnt == 0, "R6 edge sets cen", int'(cen), 1);
        tick(5);
        chk(cnt == 5, "R6 running", int'(cnt), 5);
        pulse(8'h10);
        chk(cnt == 6, "R6 later edge no effect", int'(cnt), 6);
        wr_cen(1'b0);
        chk(cnt == 7 && cen == 0, "R10 clear stops", int'(cnt), 7);
        tick(4);
        chk(cnt == 7, "R10 stopped", int'(cnt), 7);

        // R7 edge-clock mode
        do_reset(7, 7, 0);
        for (int i = 0; i < 6; i++) begin
            pulse(8'h80);
            tick(1);
        end
        chk(cnt == 6, "R7 six edges", int'(cnt), 6);
        trig_in = 8'h80;
        tick(5);
        trig_in = '0;
        chk(cnt == 7, "R7 level once", int'(cnt), 7);

        // R8 select sweep, R9 trgo off without sync
        for (int s = 0; s < N_TRIG; s++) begin
            do_reset(7, s, 0);
            trig_in = ~(N_TRIG'(1) << s);
            #1;
            chk(trgo == 0, "R9 trgo off", int'(trgo), 0);
            tick(1);
            trig_in = '0;
            tick(1);
            chk(cnt == 0, "R8 other lines ignored", int'(cnt), 0);
            pulse(N_TRIG'(1) << s);
            chk(int'(cnt) == ((s == 3) ? 0 : 1), "R8 selected line", int'(cnt), (s == 3) ? 0 : 1);
        end

        // R9 sync delay
        do_reset(7, 2, 1);
        trig_in = 8'h04;
        #1;
        chk(trgo == 1, "R9 trgo pulse", int'(trgo), 1);
        tick(1);
        trig_in = '0;
        chk(cnt == 0, "R9 delayed", int'(cnt), 0);
        tick(1);
        chk(cnt == 1, "R9 acts one later", int'(cnt), 1);

        // R1 decoder-owned modes
        for (int m = 1; m <= 3; m++) begin
            do_reset(m, 0, 0);
            wr_cen(1'b1);
            pulse('1);
            tick(6);
            chk(cnt == 0, "R1 enc holds", int'(cnt), 0);
            chk(int'(enc_mode) == m, "R1 enc_mode", int'(enc_mode), m);
        end
        // R1 mode change takes effect one cycle later
        mode_sel = 3'd0;
        tick(1);
        chk(cnt == 0 && enc_mode == 0, "R1 change latency", int'(cnt), 0);
        tick(1);
        chk(cnt == 1, "R1 idle after change", int'(cnt), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule